// File: doc/BRIEF.md
# Keyless Sponge Round Permutation

This block is the permutation of a duplex sponge. It holds a 1024-bit state as sixteen 64-bit words and scrambles that state with an add-rotate-xor round. A single-cycle start pulse loads a new state and a round count. The block then runs one round per clock. It pulses a completion flag when the last round is done, and the permuted state stays on the output until the next accepted start.

The surrounding sponge controller asks for twelve rounds for a full permutation. It asks for one round for the cheap permutation used between memory accesses. Any count from 0 to 15 is accepted, and a count of zero returns the loaded state unchanged. The mixing function takes no message words and no round constants, so each round depends only on the current state.

Top module: `sponge_perm`

## Requirements
- R1: After reset, done_o and busy_o are low and state_o is all zeros.
- R2: A start_i pulse while busy_o is low loads state_i and captures rounds_i. If rounds_i is nonzero, busy_o is high after that clock edge.
- R3: With rounds_i = N > 0, one round is applied per clock. busy_o stays high, and done_o low, for the N-1 edges after the start edge. At the Nth edge after the start edge, done_o rises, busy_o falls and state_o carries the result.
- R4: With rounds_i = 0, done_o is high right after the start edge and state_o equals state_i.
- R5: Word k of the state occupies bits [64k+63:64k]. The mix on words (a,b,c,d) runs these steps in order: a+=b; d^=a; d rotated right 32; c+=d; b^=c; b rotated right 24; a+=b; d^=a; d rotated right 16; c+=d; b^=c; b rotated right 63. Additions are modulo 2^64.
- R6: One round mixes the column groups (0,4,8,12), (1,5,9,13), (2,6,10,14) and (3,7,11,15). It then mixes the diagonal groups (0,5,10,15), (1,6,11,12), (2,7,8,13) and (3,4,9,14) on the updated words. rounds_i = 12 gives twelve such rounds, and rounds_i = 1 gives one.
- R7: done_o is high for exactly one cycle per accepted start.
- R8: A start_i pulse while busy_o is high is ignored. The running permutation finishes with the result of the originally loaded state.
- R9: After done_o, state_o holds its value until the next accepted start.
- R10: The all-zero state maps to the all-zero state for any round count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load state and round count when idle |
| rounds_i | input | 4 | Number of rounds to apply |
| state_i | input | 1024 | State to permute |
| state_o | output | 1024 | Current or permuted state |
| busy_o | output | 1 | Rounds are in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |

## Verification
Every round count from 0 to 15 is run on several random states. This separates errors in the round function from errors in the round counter, including off-by-one errors at the single-round and full twelve-round counts. The all-zero state is a fixed point, so a nonzero result there exposes a stray constant. An all-ones state exposes a wrong rotation amount or group wiring within a single round. A start pulse during a running permutation, and idle cycles after completion, show whether the loaded state can be disturbed or the result lost.

// File: rtl/sponge_perm_pkg.sv
package sponge_perm_pkg;
  parameter int unsigned WORD_W  = 64;
  parameter int unsigned N_WORDS = 16;
  parameter int unsigned ROT_A   = 32;
  parameter int unsigned ROT_B   = 24;
  parameter int unsigned ROT_C   = 16;
  parameter int unsigned ROT_D   = 63;
  parameter int unsigned ROUND_W = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [N_WORDS-1:0][WORD_W-1:0] state_t;

  function automatic word_t rotr(word_t x, int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction
endpackage

// File: rtl/perm_g_mix.sv
module perm_g_mix
  import sponge_perm_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);
  word_t a1, b1, c1, d1;
  word_t a2, b2, c2, d2;

  always_comb begin
    a1 = a_i + b_i;
    d1 = rotr(d_i ^ a1, ROT_A);
    c1 = c_i + d1;
    b1 = rotr(b_i ^ c1, ROT_B);
    a2 = a1 + b1;
    d2 = rotr(d1 ^ a2, ROT_C);
    c2 = c1 + d2;
    b2 = rotr(b1 ^ c2, ROT_D);
  end

  assign a_o = a2;
  assign b_o = b2;
  assign c_o = c2;
  assign d_o = d2;
endmodule

// File: rtl/perm_round.sv
module perm_round
  import sponge_perm_pkg::*;
(
  input  state_t st_i,
  output state_t st_o
);
  localparam int unsigned LANES = N_WORDS / 4;

  state_t mid;

  for (genvar i = 0; i < LANES; i++) begin : g_col
    localparam int unsigned IA = i;
    localparam int unsigned IB = i + LANES;
    localparam int unsigned IC = i + 2 * LANES;
    localparam int unsigned ID = i + 3 * LANES;
    perm_g_mix u_g (
      .a_i(st_i[IA]), .b_i(st_i[IB]), .c_i(st_i[IC]), .d_i(st_i[ID]),
      .a_o(mid[IA]),  .b_o(mid[IB]),  .c_o(mid[IC]),  .d_o(mid[ID])
    );
  end

  // diagonal: lane i takes the word shifted i+k positions in row k
  for (genvar i = 0; i < LANES; i++) begin : g_diag
    localparam int unsigned IA = i;
    localparam int unsigned IB = LANES + (i + 1) % LANES;
    localparam int unsigned IC = 2 * LANES + (i + 2) % LANES;
    localparam int unsigned ID = 3 * LANES + (i + 3) % LANES;
    perm_g_mix u_g (
      .a_i(mid[IA]),  .b_i(mid[IB]),  .c_i(mid[IC]),  .d_i(mid[ID]),
      .a_o(st_o[IA]), .b_o(st_o[IB]), .c_o(st_o[IC]), .d_o(st_o[ID])
    );
  end
endmodule

// File: rtl/perm_ctrl.sv
module perm_ctrl
  import sponge_perm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ROUND_W-1:0] rounds_i,
  output logic               load_o,
  output logic               busy_o,
  output logic               done_o
);
  logic [ROUND_W-1:0] cnt_q;
  logic               busy_q, done_q;

  assign load_o = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        cnt_q  <= rounds_i;
        busy_q <= (rounds_i != '0);
        done_q <= (rounds_i == '0);
      end else if (busy_q) begin
        cnt_q <= cnt_q - ROUND_W'(1);
        if (cnt_q == ROUND_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_q && busy_q)); // R3
  AST_ZERO_ROUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q && rounds_i == '0) |=> (done_q && !busy_q)); // R4
  AST_BUSY_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q > ROUND_W'(1)) |=> (busy_q && !done_q)); // R3
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q && rounds_i != '0) |=> busy_q); // R2
endmodule

// File: rtl/sponge_perm.sv
module sponge_perm
  import sponge_perm_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [ROUND_W-1:0]          rounds_i,
  input  logic [N_WORDS*WORD_W-1:0]   state_i,
  output logic [N_WORDS*WORD_W-1:0]   state_o,
  output logic                        busy_o,
  output logic                        done_o
);
  state_t st_q, st_next;
  logic   load, busy, done;

  perm_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .rounds_i(rounds_i),
    .load_o  (load),
    .busy_o  (busy),
    .done_o  (done)
  );

  perm_round u_round (
    .st_i(st_q),
    .st_o(st_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= '0;
    else if (load)  st_q <= state_t'(state_i);
    else if (busy)  st_q <= st_next;
  end

  assign state_o = st_q;
  assign busy_o  = busy;
  assign done_o  = done;

  AST_STATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> $stable(st_q)); // R9
  AST_LOAD_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy) |=> (st_q == state_t'($past(state_i)))); // R2
  AST_ZERO_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && st_q == '0) |=> (st_q == '0)); // R10
endmodule

// File: tb/sponge_perm_tb.sv
module sponge_perm_tb;
  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [3:0]    rounds_i = '0;
  logic [1023:0] state_i = '0;
  logic [1023:0] state_o;
  logic          busy_o, done_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk_i = ~clk_i;

  sponge_perm u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rounds_i(rounds_i),
    .state_i(state_i), .state_o(state_o), .busy_o(busy_o), .done_o(done_o)
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [63:0] ror(logic [63:0] x, int n);
    return (x >> n) | (x << (64 - n));
  endfunction

  // R5: reference mix, returns {a,b,c,d}
  function automatic logic [255:0] ref_mix(logic [63:0] a, logic [63:0] b,
                                           logic [63:0] c, logic [63:0] d);
    a = a + b; d = ror(d ^ a, 32);
    c = c + d; b = ror(b ^ c, 24);
    a = a + b; d = ror(d ^ a, 16);
    c = c + d; b = ror(b ^ c, 63);
    return {a, b, c, d};
  endfunction

  // R6: reference round with explicit group tables
  function automatic logic [1023:0] ref_round(logic [1023:0] s);
    logic [63:0] w [16];
    logic [255:0] r;
    int grp [8][4] = '{'{0,4,8,12}, '{1,5,9,13}, '{2,6,10,14}, '{3,7,11,15},
                       '{0,5,10,15}, '{1,6,11,12}, '{2,7,8,13}, '{3,4,9,14}};
    for (int k = 0; k < 16; k++) w[k] = s[64*k +: 64];
    for (int g = 0; g < 8; g++) begin
      r = ref_mix(w[grp[g][0]], w[grp[g][1]], w[grp[g][2]], w[grp[g][3]]);
      w[grp[g][0]] = r[255:192];
      w[grp[g][1]] = r[191:128];
      w[grp[g][2]] = r[127:64];
      w[grp[g][3]] = r[63:0];
    end
    for (int k = 0; k < 16; k++) s[64*k +: 64] = w[k];
    return s;
  endfunction

  function automatic logic [1023:0] ref_perm(logic [1023:0] s, int n);
    for (int k = 0; k < n; k++) s = ref_round(s);
    return s;
  endfunction

  function automatic logic [1023:0] rand_state();
    logic [1023:0] s;
    for (int k = 0; k < 32; k++) s[32*k +: 32] = $urandom;
    return s;
  endfunction

  task automatic chk(bit ok, string req, logic [1023:0] act, logic [1023:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [1023:0] s, int n, bit poke);
    logic [1023:0] exp;
    exp = ref_perm(s, n);
    @(negedge clk_i);
    start_i = 1'b1; rounds_i = 4'(n); state_i = s;
    @(negedge clk_i);
    start_i = 1'b0; state_i = ~s;
    if (n == 0) begin
      chk(done_o && !busy_o, "R4 done after zero rounds", {1022'd0, done_o, busy_o}, 1024'd2);
      chk(state_o == s, "R4 passthrough", state_o, s);
    end else begin
      chk(busy_o && !done_o, "R2 busy after start", {1022'd0, busy_o, done_o}, 1024'd2);
      for (int k = 1; k < n; k++) begin
        if (poke && k == 1) begin
          start_i = 1'b1; rounds_i = 4'd0;
        end
        @(negedge clk_i);
        start_i = 1'b0;
        chk(busy_o && !done_o, "R3 running", {1022'd0, busy_o, done_o}, 1024'd2);
      end
      @(negedge clk_i);
      chk(done_o && !busy_o, "R3 done timing", {1022'd0, done_o, busy_o}, 1024'd2);
      if (poke) chk(state_o == exp, "R8 start ignored while busy", state_o, exp);
      else if (s == '0) chk(state_o == '0, "R10 zero fixed point", state_o, '0);
      else chk(state_o == exp, "R6 R5 result", state_o, exp);
    end
    @(negedge clk_i);
    chk(!done_o, "R7 single-cycle done", {1023'd0, done_o}, '0);
    @(negedge clk_i);
    chk(state_o == exp, "R9 result held", state_o, exp);
  endtask

  initial begin
    #1;
    chk(!done_o && !busy_o && state_o == '0, "R1 reset state", state_o, '0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk(!done_o && !busy_o && state_o == '0, "R1 after reset release", state_o, '0);

    run('0, 12, 1'b0);                    // R10
    run({1024{1'b1}}, 1, 1'b0);           // R5 single round
    run(1024'h1, 1, 1'b0);                // R6 single bit spread
    for (int n = 0; n < 16; n++)
      for (int t = 0; t < 3; t++)
        run(rand_state(), n, 1'b0);       // R3 R6 sweep
    run(rand_state(), 12, 1'b1);          // R8
    run(rand_state(), 2, 1'b1);           // R8 short run

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule